// File: doc/BRIEF.md
# Intel HEX Record Command Decoder

This block sits behind a UART receiver and turns a stream of ASCII characters, each presented as a byte with a one-cycle valid strobe, into programming commands. It recognises records made of a colon followed by hexadecimal digit pairs. The pairs carry, in this order, a data byte count, a 16-bit start address, a record type, the data bytes and a checksum. Digits may be upper or lower case. Up to 16 data bytes are held internally while the running checksum is accumulated.

No operation starts before the last checksum digit has arrived and the checksum has been verified. A valid record is then either answered at once or handed to a memory-programming agent through a command port. That port carries the type, the address, the byte count, the data, and the subfunction and selection bytes. The agent answers with a done strobe and a fail flag. Every record, and every record abandoned part-way, ends with exactly one ASCII status character for the transmitter:
- `.` for success,
- `X` for a malformed record or a checksum error,
- `R` for a refused or failed operation.

The block enforces one ordering rule: data records are refused until an oscillator-setup record has completed without failure. Miscellaneous write records, which cover erase, security, status and boot-vector commands, are checked against their legal subfunction and selection codes before they are dispatched.

Top module: `hexrec_cmd_dec`

## Requirements
- R1: Characters are ignored while no record is open: nothing is emitted until ':' (0x3A) arrives. Trailing CR/LF after the checksum has no effect. Hex digits 0-9, A-F and a-f are all accepted.
- R2: A count byte above 16 aborts the record at once with status 'X' (0x58) and no command. Counts 0 to 16 are accepted.
- R3: Any non-hex character inside a record, including a second ':', aborts it with 'X'. Until the next ':' no further status is produced.
- R4: Record types above 0x03 abort the record with 'X' and no command.
- R5: A record is valid only when the 8-bit sum of every byte from the count through the checksum is zero. Otherwise it is answered 'X' and not dispatched.
- R6: Type 0x01 (end of file) with a good checksum is answered '.' (0x2E) without a command, whatever its address field holds.
- R7: Type 0x00 (data) is answered 'R' (0x52) and not dispatched until a type 0x02 record has completed without fail. After that it is dispatched.
- R8: A dispatched command holds cmd_valid until cmd_done is sampled high. It presents cmd_type, cmd_addr and cmd_len (the count), with data byte k at cmd_data[8k+7:8k], cmd_subfn equal to data byte 0 and cmd_sel equal to data byte 1.
- R9: When cmd_done is sampled high, the status is 'R' if cmd_fail is high and '.' otherwise. A type 0x02 record completes the ordering rule only when cmd_fail is low.
- R10: Type 0x03 needs at least 2 data bytes, and its subfunction (byte 0) and selection (byte 1) must be legal:
  - 0x01 takes selection 0x00, 0x20, 0x40, 0x80 or 0xC0.
  - 0x04 takes any selection.
  - 0x05 takes selection 0 to 2.
  - 0x06 takes selection 0 or 1 with a third byte, or selection 2 with third byte 0x80.
  
  Any other combination is answered 'X' and not dispatched.
- R11: Each record or abort yields exactly one st_valid pulse of one cycle. Characters arriving between the checksum and that pulse are ignored. After reset, cmd_valid and st_valid are low.
- R12: Type 0x02 with zero data bytes is answered 'X' and not dispatched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_data | input | 8 | Received ASCII character |
| rx_valid | input | 1 | One-cycle strobe for rx_data |
| cmd_valid | output | 1 | Command pending for the programming agent |
| cmd_type | output | 8 | Record type of the command |
| cmd_addr | output | 16 | Record start address |
| cmd_len | output | 5 | Number of data bytes |
| cmd_subfn | output | 8 | Data byte 0 (subfunction) |
| cmd_sel | output | 8 | Data byte 1 (selection) |
| cmd_data | output | 128 | Data bytes, byte k at bits 8k+7:8k |
| cmd_done | input | 1 | Agent finished the pending command |
| cmd_fail | input | 1 | Qualifies cmd_done: operation failed |
| st_valid | output | 1 | One-cycle strobe for st_char |
| st_char | output | 8 | Status character '.', 'X' or 'R' |

## Verification
The assertions assume that the programming agent raises cmd_done only while cmd_valid is high and drops it after one cycle. The bench responder follows this rule: it strobes done once, after a programmable delay, only for a pending command. The receive side is unconstrained. The bench sends characters one every other cycle, including a full sweep of all 256 codes in a digit position and characters sent deliberately while a command is still pending.

// File: rtl/hexrec_pkg.sv
// Shared constants and types for the HEX record command decoder.
// Assumes ASCII character coding on the receive and status paths.
package hexrec_pkg;

    localparam logic [7:0] CH_COLON = 8'h3A;
    localparam logic [7:0] CH_DOT   = 8'h2E;
    localparam logic [7:0] CH_X     = 8'h58;
    localparam logic [7:0] CH_R     = 8'h52;

    localparam logic [7:0] RT_DATA  = 8'h00;
    localparam logic [7:0] RT_EOF   = 8'h01;
    localparam logic [7:0] RT_OSC   = 8'h02;
    localparam logic [7:0] RT_MISC  = 8'h03;

    // field of the record whose digit pair is being collected
    typedef enum logic [2:0] {
        F_CNT, F_AH, F_AL, F_TYP, F_DAT, F_CS
    } field_e;

    // character-level parser state
    typedef enum logic [1:0] {
        P_IDLE, P_HI, P_LO, P_WAIT
    } pstate_e;

    // dispatcher state
    typedef enum logic {
        D_IDLE, D_CMD
    } dstate_e;

    // verdict taken on a finished or aborted record
    typedef enum logic [2:0] {
        A_NONE, A_X, A_DOT, A_R, A_SEND
    } act_e;

endpackage

// File: rtl/hexrec_nibble.sv
// ASCII hex digit classifier.
// Maps '0'-'9', 'A'-'F' and 'a'-'f' to a 4-bit value and flags every
// other code as non-hex. Purely combinational.
module hexrec_nibble (
    input  logic [7:0] ch,
    output logic [3:0] nib,
    output logic       is_hex
);

    // classify one character and derive its value
    always_comb begin
        is_hex = 1'b0;
        nib    = ch[3:0];
        if (ch >= 8'h30 && ch <= 8'h39) begin
            is_hex = 1'b1;
        end else if ((ch >= 8'h41 && ch <= 8'h46) || (ch >= 8'h61 && ch <= 8'h66)) begin
            is_hex = 1'b1;
            nib    = ch[3:0] + 4'd9;
        end
    end

endmodule

// File: rtl/hexrec_parser.sv
// Record parser: walks the fields of one HEX record, assembles digit
// pairs into bytes, keeps a running 8-bit checksum and stores the data
// bytes. Emits rec_done (with rec_ok) after the checksum byte, or
// rec_abort on a malformed record. After rec_done it holds its fields
// and ignores input until release_i. Assumes MAX_BYTES >= 3.
module hexrec_parser #(
    parameter int MAX_BYTES = 16,
    localparam int CNT_W    = $clog2(MAX_BYTES + 1),
    localparam int IDX_W    = $clog2(MAX_BYTES)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [7:0]             rx_data,
    input  logic                   rx_valid,
    input  logic [3:0]             nib,
    input  logic                   is_hex,
    input  logic                   release_i,
    output logic                   rec_done,
    output logic                   rec_ok,
    output logic                   rec_abort,
    output logic [CNT_W-1:0]       rec_cnt,
    output logic [15:0]            rec_addr,
    output logic [7:0]             rec_type,
    output logic [MAX_BYTES*8-1:0] rec_data
);
    import hexrec_pkg::*;

    localparam logic [7:0] MAX_B8 = 8'(MAX_BYTES);

    pstate_e          st;
    field_e           fld;
    logic [3:0]       hi_q;
    logic [7:0]       sum_q;
    logic [CNT_W-1:0] idx_q;
    logic [7:0]       buf_q [MAX_BYTES];

    logic [7:0]       cur_byte;
    logic [7:0]       sum_nx;
    logic [CNT_W-1:0] idx_nx;

    // byte formed by the stored high digit and the incoming low digit
    always_comb begin
        cur_byte = {hi_q, nib};
        sum_nx   = sum_q + cur_byte;
        idx_nx   = idx_q + 1'b1;
    end

    // field sequencer, checksum accumulator and field registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= P_IDLE;
            fld       <= F_CNT;
            hi_q      <= '0;
            sum_q     <= '0;
            idx_q     <= '0;
            rec_done  <= 1'b0;
            rec_ok    <= 1'b0;
            rec_abort <= 1'b0;
            rec_cnt   <= '0;
            rec_addr  <= '0;
            rec_type  <= '0;
        end else begin
            rec_done  <= 1'b0;
            rec_abort <= 1'b0;
            case (st)
                P_IDLE: begin
                    if (rx_valid && rx_data == CH_COLON) begin
                        st    <= P_HI;
                        fld   <= F_CNT;
                        sum_q <= '0;
                        idx_q <= '0;
                    end
                end
                P_HI: begin
                    if (rx_valid) begin
                        if (is_hex) begin
                            hi_q <= nib;
                            st   <= P_LO;
                        end else begin
                            rec_abort <= 1'b1;
                            st        <= P_IDLE;
                        end
                    end
                end
                P_LO: begin
                    if (rx_valid) begin
                        if (!is_hex) begin
                            rec_abort <= 1'b1;
                            st        <= P_IDLE;
                        end else begin
                            sum_q <= sum_nx;
                            st    <= P_HI;
                            case (fld)
                                F_CNT: begin
                                    if (cur_byte > MAX_B8) begin
                                        rec_abort <= 1'b1;
                                        st        <= P_IDLE;
                                    end else begin
                                        rec_cnt <= cur_byte[CNT_W-1:0];
                                        fld     <= F_AH;
                                    end
                                end
                                F_AH: begin
                                    rec_addr[15:8] <= cur_byte;
                                    fld            <= F_AL;
                                end
                                F_AL: begin
                                    rec_addr[7:0] <= cur_byte;
                                    fld           <= F_TYP;
                                end
                                F_TYP: begin
                                    if (cur_byte > RT_MISC) begin
                                        rec_abort <= 1'b1;
                                        st        <= P_IDLE;
                                    end else begin
                                        rec_type <= cur_byte;
                                        fld      <= (rec_cnt == '0) ? F_CS : F_DAT;
                                    end
                                end
                                F_DAT: begin
                                    buf_q[idx_q[IDX_W-1:0]] <= cur_byte;
                                    idx_q                   <= idx_nx;
                                    if (idx_nx == rec_cnt) fld <= F_CS;
                                end
                                default: begin
                                    rec_done <= 1'b1;
                                    rec_ok   <= (sum_nx == 8'h00);
                                    st       <= P_WAIT;
                                end
                            endcase
                        end
                    end
                end
                default: begin
                    if (release_i) st <= P_IDLE;
                end
            endcase
        end
    end

    // flatten stored bytes onto the data bus
    for (genvar k = 0; k < MAX_BYTES; k++) begin : g_flat
        assign rec_data[8*k +: 8] = buf_q[k];
    end

    // the parser stays parked until the status has been released
    p_wait_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (st == P_WAIT && !release_i) |=> (st == P_WAIT));

    // the data index never reaches the accepted count while storing
    p_idx_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st == P_LO && fld == F_DAT) |-> (idx_q < rec_cnt && rec_cnt <= CNT_W'(MAX_BYTES)));

    // a record either completes or aborts, never both
    p_done_xor_abort_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(rec_done && rec_abort));

endmodule

// File: rtl/hexrec_dispatch.sv
// Command dispatcher: turns a finished or aborted record into either an
// immediate status character or a command toward the programming agent,
// enforces the oscillator-first rule and validates miscellaneous write
// subfunctions. Assumes cmd_done is only strobed while cmd_valid is high.
module hexrec_dispatch #(
    parameter int MAX_BYTES = 16,
    localparam int CNT_W    = $clog2(MAX_BYTES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rec_done,
    input  logic             rec_ok,
    input  logic             rec_abort,
    input  logic [CNT_W-1:0] rec_cnt,
    input  logic [7:0]       rec_type,
    input  logic [23:0]      arg_bytes,
    input  logic             cmd_done,
    input  logic             cmd_fail,
    output logic             cmd_valid,
    output logic             st_valid,
    output logic [7:0]       st_char
);
    import hexrec_pkg::*;

    dstate_e    dst;
    logic       osc_ok;
    act_e       act;
    logic       misc_ok;
    logic [7:0] sub_b, sel_b, dat_b;

    assign sub_b = arg_bytes[7:0];
    assign sel_b = arg_bytes[15:8];
    assign dat_b = arg_bytes[23:16];

    // legality of a miscellaneous write record
    always_comb begin
        misc_ok = 1'b0;
        if (rec_cnt >= CNT_W'(2)) begin
            case (sub_b)
                8'h01:   misc_ok = (sel_b == 8'h00) || (sel_b == 8'h20) || (sel_b == 8'h40)
                                || (sel_b == 8'h80) || (sel_b == 8'hC0);
                8'h04:   misc_ok = 1'b1;
                8'h05:   misc_ok = (sel_b <= 8'h02);
                8'h06:   misc_ok = (rec_cnt >= CNT_W'(3))
                                && ((sel_b <= 8'h01) || (sel_b == 8'h02 && dat_b == 8'h80));
                default: misc_ok = 1'b0;
            endcase
        end
    end

    // verdict on the record presented this cycle
    always_comb begin
        act = A_NONE;
        if (dst == D_IDLE) begin
            if (rec_abort) begin
                act = A_X;
            end else if (rec_done) begin
                if (!rec_ok) begin
                    act = A_X;
                end else begin
                    case (rec_type)
                        RT_EOF:  act = A_DOT;
                        RT_DATA: act = osc_ok ? A_SEND : A_R;
                        RT_OSC:  act = (rec_cnt == '0) ? A_X : A_SEND;
                        RT_MISC: act = misc_ok ? A_SEND : A_X;
                        default: act = A_X;
                    endcase
                end
            end
        end
    end

    // command handshake, status strobe and ordering flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dst       <= D_IDLE;
            osc_ok    <= 1'b0;
            cmd_valid <= 1'b0;
            st_valid  <= 1'b0;
            st_char   <= CH_DOT;
        end else begin
            st_valid <= 1'b0;
            if (dst == D_IDLE) begin
                case (act)
                    A_X:    begin st_valid <= 1'b1; st_char <= CH_X;   end
                    A_DOT:  begin st_valid <= 1'b1; st_char <= CH_DOT; end
                    A_R:    begin st_valid <= 1'b1; st_char <= CH_R;   end
                    A_SEND: begin cmd_valid <= 1'b1; dst <= D_CMD;     end
                    default: ;
                endcase
            end else if (cmd_done) begin
                cmd_valid <= 1'b0;
                dst       <= D_IDLE;
                st_valid  <= 1'b1;
                st_char   <= cmd_fail ? CH_R : CH_DOT;
                if (rec_type == RT_OSC && !cmd_fail) osc_ok <= 1'b1;
            end
        end
    end

    // a pending command stays up until the agent answers
    p_cmd_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_done) |=> cmd_valid);

    // the parser keeps the record fields steady while a command is pending
    p_fields_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_done) |=> ($stable(rec_type) && $stable(rec_cnt) && $stable(arg_bytes)));

    // no data record reaches the agent before the oscillator record
    p_osc_first_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && rec_type == RT_DATA) |-> osc_ok);

    // status codes come from the fixed set of three
    p_code_set_r11: assert property (@(posedge clk) disable iff (!rst_n)
        st_valid |-> (st_char == CH_X || st_char == CH_DOT || st_char == CH_R));

    // status is a single-cycle strobe and never overlaps a pending command
    p_single_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        st_valid |=> !st_valid);
    p_no_overlap_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(st_valid && cmd_valid));

endmodule

// File: rtl/hexrec_cmd_dec.sv
// Top of the HEX record command decoder: digit classifier, record
// parser and dispatcher. The command port mirrors the parser's held
// record fields; they are meaningful while cmd_valid is high.
module hexrec_cmd_dec #(
    parameter int MAX_BYTES = 16,
    localparam int CNT_W    = $clog2(MAX_BYTES + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [7:0]             rx_data,
    input  logic                   rx_valid,
    output logic                   cmd_valid,
    output logic [7:0]             cmd_type,
    output logic [15:0]            cmd_addr,
    output logic [CNT_W-1:0]       cmd_len,
    output logic [7:0]             cmd_subfn,
    output logic [7:0]             cmd_sel,
    output logic [MAX_BYTES*8-1:0] cmd_data,
    input  logic                   cmd_done,
    input  logic                   cmd_fail,
    output logic                   st_valid,
    output logic [7:0]             st_char
);

    logic [3:0]             nib;
    logic                   is_hex;
    logic                   rec_done, rec_ok, rec_abort;
    logic [CNT_W-1:0]       rec_cnt;
    logic [15:0]            rec_addr;
    logic [7:0]             rec_type;
    logic [MAX_BYTES*8-1:0] rec_data;

    hexrec_nibble u_nib (
        .ch     (rx_data),
        .nib    (nib),
        .is_hex (is_hex)
    );

    hexrec_parser #(.MAX_BYTES(MAX_BYTES)) u_parse (
        .clk       (clk),
        .rst_n     (rst_n),
        .rx_data   (rx_data),
        .rx_valid  (rx_valid),
        .nib       (nib),
        .is_hex    (is_hex),
        .release_i (st_valid),
        .rec_done  (rec_done),
        .rec_ok    (rec_ok),
        .rec_abort (rec_abort),
        .rec_cnt   (rec_cnt),
        .rec_addr  (rec_addr),
        .rec_type  (rec_type),
        .rec_data  (rec_data)
    );

    hexrec_dispatch #(.MAX_BYTES(MAX_BYTES)) u_disp (
        .clk       (clk),
        .rst_n     (rst_n),
        .rec_done  (rec_done),
        .rec_ok    (rec_ok),
        .rec_abort (rec_abort),
        .rec_cnt   (rec_cnt),
        .rec_type  (rec_type),
        .arg_bytes (rec_data[23:0]),
        .cmd_done  (cmd_done),
        .cmd_fail  (cmd_fail),
        .cmd_valid (cmd_valid),
        .st_valid  (st_valid),
        .st_char   (st_char)
    );

    assign cmd_type  = rec_type;
    assign cmd_addr  = rec_addr;
    assign cmd_len   = rec_cnt;
    assign cmd_subfn = rec_data[7:0];
    assign cmd_sel   = rec_data[15:8];
    assign cmd_data  = rec_data;

endmodule

// File: tb/hexrec_cmd_dec_tb.sv
`timescale 1ns/100ps
module hexrec_cmd_dec_tb_top;

    localparam int MAXB = 16;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [7:0]      rx_data = 8'h00;
    logic            rx_valid = 1'b0;
    logic            cmd_valid;
    logic [7:0]      cmd_type;
    logic [15:0]     cmd_addr;
    logic [4:0]      cmd_len;
    logic [7:0]      cmd_subfn, cmd_sel;
    logic [MAXB*8-1:0] cmd_data;
    logic            cmd_done = 1'b0;
    logic            cmd_fail = 1'b0;
    logic            st_valid;
    logic [7:0]      st_char;

    hexrec_cmd_dec #(.MAX_BYTES(MAXB)) dut_i (
        .clk(clk), .rst_n(rst_n), .rx_data(rx_data), .rx_valid(rx_valid),
        .cmd_valid(cmd_valid), .cmd_type(cmd_type), .cmd_addr(cmd_addr),
        .cmd_len(cmd_len), .cmd_subfn(cmd_subfn), .cmd_sel(cmd_sel),
        .cmd_data(cmd_data), .cmd_done(cmd_done), .cmd_fail(cmd_fail),
        .st_valid(st_valid), .st_char(st_char)
    );

    always #2.5 clk = ~clk;

    int n_chk = 0, n_err = 0;
    int st_cnt = 0, cmd_cnt = 0;
    logic [7:0] last_st = 8'h00;
    int resp_dly = 1, dly = 0;
    logic resp_fail = 1'b0;
    logic [7:0] cap_type, cap_sub, cap_sel;
    logic [15:0] cap_addr;
    logic [4:0] cap_len;
    logic [MAXB*8-1:0] cap_data;
    logic [7:0] pl [32];

    // status monitor, sampled mid-cycle
    always @(negedge clk) begin
        if (st_valid) begin
            st_cnt++;
            last_st = st_char;
        end
    end

    // programming agent model: one done strobe after resp_dly cycles
    always @(negedge clk) begin
        if (cmd_valid && !cmd_done) begin
            if (dly >= resp_dly) begin
                cmd_done = 1'b1;
                cmd_fail = resp_fail;
                dly = 0;
                cmd_cnt++;
                cap_type = cmd_type; cap_addr = cmd_addr; cap_len = cmd_len;
                cap_sub = cmd_subfn; cap_sel = cmd_sel; cap_data = cmd_data;
            end else dly++;
        end else begin
            cmd_done = 1'b0;
            cmd_fail = 1'b0;
        end
    end

    task automatic finish_up();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_up();
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic send_char(input logic [7:0] c);
        @(negedge clk);
        rx_data = c;
        rx_valid = 1'b1;
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    function automatic logic [7:0] hexch(input logic [3:0] d, input bit lc);
        if (d < 4'd10) return 8'h30 + 8'(d);
        return (lc ? 8'h57 : 8'h37) + 8'(d);
    endfunction

    task automatic send_hex(input logic [7:0] b, input bit lc);
        send_char(hexch(b[7:4], lc));
        send_char(hexch(b[3:0], lc));
    endtask

    // full record with computed checksum plus adj, then CR LF
    task automatic send_frame(input int n, input logic [15:0] a, input logic [7:0] t,
                              input logic [7:0] adj, input bit lc);
        logic [7:0] s;
        s = 8'(n) + a[15:8] + a[7:0] + t;
        send_char(8'h3A);
        send_hex(8'(n), lc);
        send_hex(a[15:8], lc);
        send_hex(a[7:0], lc);
        send_hex(t, lc);
        for (int k = 0; k < n; k++) begin
            send_hex(pl[k], lc);
            s = s + pl[k];
        end
        send_hex(8'(-s) + adj, lc);
        send_char(8'h0D);
        send_char(8'h0A);
    endtask

    task automatic wait_status(input int prev);
        for (int i = 0; i < 80 && st_cnt == prev; i++) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    task automatic expect_rec(input string req, input int n, input logic [15:0] a,
                              input logic [7:0] t, input logic [7:0] adj, input bit lc,
                              input logic [7:0] exp_ch, input int exp_cmds);
        int ps, pc;
        ps = st_cnt;
        pc = cmd_cnt;
        send_frame(n, a, t, adj, lc);
        wait_status(ps);
        chk(req, "status char", int'(last_st), int'(exp_ch));
        chk(req, "status pulses", st_cnt - ps, 1);
        chk(req, "commands", cmd_cnt - pc, exp_cmds);
    endtask

    function automatic bit misc_legal(input int sub, input int sel, input int d2);
        case (sub)
            1: return sel == 0 || sel == 32 || sel == 64 || sel == 128 || sel == 192;
            4: return 1'b1;
            5: return sel < 3;
            6: return sel < 2 || (sel == 2 && d2 == 128);
            default: return 1'b0;
        endcase
    endfunction

    initial begin
        repeat (4) @(negedge clk);
        // R11: reset state
        chk("R11", "cmd_valid in reset", int'(cmd_valid), 0);
        chk("R11", "st_valid in reset", int'(st_valid), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1: junk outside a record produces nothing
        send_char(8'h5A); send_char(8'h35); send_char(8'h0D); send_char(8'h0A);
        repeat (6) @(negedge clk);
        chk("R1", "status pulses for junk", st_cnt, 0);

        // R7: data before oscillator setup is refused
        pl[0] = 8'h11; pl[1] = 8'h22;
        expect_rec("R7", 2, 16'h1234, 8'h00, 8'h00, 1'b0, 8'h52, 0);

        // R9: oscillator record failing leaves the rule unmet
        resp_fail = 1'b1;
        pl[0] = 8'h0C;
        expect_rec("R9", 1, 16'h0000, 8'h02, 8'h00, 1'b0, 8'h52, 1);
        resp_fail = 1'b0;
        pl[0] = 8'h33;
        expect_rec("R7", 1, 16'h0010, 8'h00, 8'h00, 1'b0, 8'h52, 0);

        // R12: empty oscillator record
        expect_rec("R12", 0, 16'h0000, 8'h02, 8'h00, 1'b0, 8'h58, 0);

        // R9: successful oscillator record
        pl[0] = 8'h0C;
        expect_rec("R9", 1, 16'h0000, 8'h02, 8'h00, 1'b1, 8'h2E, 1);
        chk("R8", "osc cmd type", int'(cap_type), 2);

        // R6: end of file, address ignored
        expect_rec("R6", 0, 16'hBEEF, 8'h01, 8'h00, 1'b0, 8'h2E, 0);

        // R5: bad checksum
        pl[0] = 8'h01; pl[1] = 8'h02; pl[2] = 8'h03;
        expect_rec("R5", 3, 16'h0200, 8'h00, 8'h01, 1'b0, 8'h58, 0);

        // R4: unknown record types
        for (int t = 4; t < 9; t++)
            expect_rec("R4", 0, 16'h0000, 8'(t), 8'h00, 1'b0, 8'h58, 0);
        expect_rec("R4", 0, 16'h0000, 8'hFF, 8'h00, 1'b0, 8'h58, 0);

        // R2 / R8: count sweep 0..17 on data records
        for (int n = 0; n < 18; n++) begin
            for (int k = 0; k < 32; k++) pl[k] = 8'(n * 7 + k * 13 + 5);
            if (n <= MAXB) begin
                expect_rec("R2", n, 16'(n * 273), 8'h00, 8'h00, 1'(n % 2), 8'h2E, 1);
                chk("R8", "len", int'(cap_len), n);
                chk("R8", "addr", int'(cap_addr), (n * 273) & 16'hFFFF);
                chk("R8", "type", int'(cap_type), 0);
                for (int k = 0; k < n; k++)
                    chk("R8", "data byte", int'(cap_data[8*k +: 8]), int'(pl[k]));
            end else begin
                expect_rec("R2", n, 16'h0000, 8'h00, 8'h00, 1'b0, 8'h58, 0);
            end
        end

        // R9: failed programming of a data record
        resp_fail = 1'b1;
        pl[0] = 8'hA5;
        expect_rec("R9", 1, 16'h0400, 8'h00, 8'h00, 1'b0, 8'h52, 1);
        resp_fail = 1'b0;

        // R3: every character code in the checksum high digit of an EOF record
        for (int c = 0; c < 256; c++) begin
            int ps;
            logic [7:0] ex;
            ps = st_cnt;
            send_char(8'h3A);
            send_hex(8'h00, 1'b0); send_hex(8'h00, 1'b0); send_hex(8'h00, 1'b0); send_hex(8'h01, 1'b0);
            send_char(8'(c));
            send_char(8'h46);
            send_char(8'h0D);
            send_char(8'h0A);
            wait_status(ps);
            ex = (c == 8'h46 || c == 8'h66) ? 8'h2E : 8'h58;
            chk("R3", "status char", int'(last_st), int'(ex));
            chk("R3", "status pulses", st_cnt - ps, 1);
        end

        // R10: subfunction / selection sweep on miscellaneous writes
        for (int si = 0; si < 7; si++) begin
            int sub;
            sub = (si < 3) ? si : si + 1;
            for (int sel = 0; sel < 256; sel++) begin
                bit ok;
                pl[0] = 8'(sub);
                pl[1] = 8'(sel);
                pl[2] = sel[0] ? 8'h11 : 8'h80;
                ok = misc_legal(sub, sel, int'(pl[2]));
                expect_rec("R10", 3, 16'h0000, 8'h03, 8'h00, 1'b0, ok ? 8'h2E : 8'h58, ok ? 1 : 0);
                if (ok) begin
                    chk("R8", "subfn", int'(cap_sub), sub);
                    chk("R8", "sel", int'(cap_sel), sel);
                end
            end
        end
        pl[0] = 8'h06; pl[1] = 8'h00;
        expect_rec("R10", 2, 16'h0000, 8'h03, 8'h00, 1'b0, 8'h58, 0);
        pl[0] = 8'h04;
        expect_rec("R10", 1, 16'h0000, 8'h03, 8'h00, 1'b0, 8'h58, 0);

        // R11: characters during a pending command are ignored
        begin
            int ps;
            resp_dly = 20;
            ps = st_cnt;
            pl[0] = 8'h04; pl[1] = 8'h00;
            send_frame(2, 16'h0000, 8'h03, 8'h00, 1'b0);
            send_char(8'h3A);
            send_char(8'h30);
            wait_status(ps);
            send_char(8'h30);
            send_hex(8'h00, 1'b0); send_hex(8'h00, 1'b0); send_hex(8'h01, 1'b0); send_hex(8'hFF, 1'b0);
            repeat (40) @(negedge clk);
            chk("R11", "pulses with chars during command", st_cnt - ps, 1);
            chk("R11", "status after pending command", int'(last_st), 8'h2E);
            resp_dly = 1;
        end

        finish_up();
    end

endmodule